// File: doc/BRIEF.md
# Stepper Microstep Phase Sequencer

This block turns a slow step clock into two signed coil-current setpoints for a two-phase bipolar stepper motor. Each rising edge of the step clock moves an internal electrical position one step forward or backward. The position is a 6-bit index that covers one electrical turn in 64 slots, 16 slots per quarter turn. The two setpoints are signed percentage codes that an analog current regulator uses as its reference. Coil A follows a cosine-like curve of the position, and coil B follows the same curve shifted by a quarter turn.

A two-bit mode input selects the step resolution: full-step with both coils energised, half-step, eighth-step or sixteenth-step. The coarser modes reuse the sixteenth-step quarter-wave table by moving further through it on each step. A two-bit torque input scales both setpoints. An active-low home input returns the sequencer to its home state and holds it there. An enable input forces both setpoints to zero, but the position keeps counting. The block also drives a home flag and a one-cycle step-event pulse, which a chopper uses to restart its PWM period.

Top module: `stepper_phase_seq`

## Requirements
- R1: The position advances by a stride set by `mode_sel` on each accepted step: 16 for `00` (full-step, both coils on), 8 for `01` (half-step), 1 for `10` (sixteenth-step) and 2 for `11` (eighth-step). The position wraps modulo 64.
- R2: In the three microstep modes, coil A at position p comes from quadrant q = p[5:4] and remainder r = p[3:0]. Quadrants 0 and 2 use table entry T[r], and quadrants 1 and 3 use T[16-r]. The sign is negative in quadrants 1 and 2. T[0..15] = 100,100,98,96,92,88,83,77,71,63,56,47,38,29,20,10, and T[16] = 0. Coil B applies the same rule at position (p+16) mod 64.
- R3: In full-step mode (`00`), both coils carry magnitude 100. Over quadrants 0,1,2,3 the signs of (A,B) are (+,-), (-,-), (-,+), (+,+).
- R4: The home state is position 0. In that state A = +100 and B = -100 in full-step mode, and A = +100 and B = 0 in every other mode (before torque scaling).
- R5: `dir_in` low increments the position (clockwise). `dir_in` high decrements it (counter-clockwise).
- R6: While `home_n` is low, step edges are ignored and raise no `step_pulse`. The setpoints show the home state, `at_home` is high, and the position returns to 0.
- R7: `at_home` is high whenever the position is 0, including when a step sequence wraps back to it.
- R8: After `home_n` rises, the first accepted step moves to the state that follows home in the selected direction.
- R9: While `enable` is low, both setpoints read 0 and steps still advance the position. When `enable` goes high again, the setpoints show the current position.
- R10: The magnitude is scaled to floor(mag*pct/100), where pct is 100, 75, 50 or 20 for `torque_sel` 00, 01, 10 or 11. The sign is applied after scaling.
- R11: Each rising edge of `step_in` that is accepted produces a `step_pulse` exactly one clock long. The pulse goes high on the third rising clock edge after the input rises, and the new setpoints appear in the same cycle as the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_in | input | 1 | Asynchronous step clock; each rising edge is one step |
| dir_in | input | 1 | Direction: 0 clockwise, 1 counter-clockwise |
| mode_sel | input | 2 | Step resolution select |
| torque_sel | input | 2 | Current scaling select |
| home_n | input | 1 | Active-low return-to-home and hold |
| enable | input | 1 | High lets the setpoints through; low forces them to zero |
| coil_a | output | 8 | Signed percentage setpoint for coil A |
| coil_b | output | 8 | Signed percentage setpoint for coil B |
| at_home | output | 1 | High when the sequencer is in the home state |
| step_pulse | output | 1 | One-cycle pulse for each accepted step |

## Verification
The assertions assume that `home_n`, `mode_sel`, `torque_sel`, `enable` and `dir_in` are already synchronous to `clk`. They also assume that every high and low phase of `step_in` lasts at least three clock cycles, so that each edge gets through the synchronizer by itself. The resolution is assumed to change only while `home_n` holds the sequencer at home, so the position always sits on the grid of the new stride. The stimulus keeps to all of this: it changes `mode_sel` only inside a home-hold window, holds each step level for three or more cycles, and changes the control inputs only between clock edges.

// File: rtl/stepseq_pkg.sv
// Package: shared sizes, the resolution encoding and the quarter-wave table.
// Assumes a 16-slot quarter wave (QTR_W = 4); the table below is written for it.
package stepseq_pkg;

    localparam int QTR_W     = 4;
    localparam int POS_W     = QTR_W + 2;
    localparam int QTR_STEPS = 1 << QTR_W;
    localparam int OUT_W     = 8;
    localparam int MAG_W     = 7;
    localparam int PCT_W     = 7;
    localparam int PROD_W    = MAG_W + PCT_W;
    localparam int NUM_COILS = 2;
    localparam int FULL_MAG  = 100;

    typedef enum logic [1:0] {
        RES_FULL      = 2'b00,
        RES_HALF      = 2'b01,
        RES_SIXTEENTH = 2'b10,
        RES_EIGHTH    = 2'b11
    } res_mode_e;

    // Quarter-wave magnitude in percent; index QTR_STEPS and above give zero.
    function automatic logic [MAG_W-1:0] quarter_mag(input logic [QTR_W:0] idx);
        logic [MAG_W-1:0] m;
        case (idx)
            5'd0:    m = 7'd100;
            5'd1:    m = 7'd100;
            5'd2:    m = 7'd98;
            5'd3:    m = 7'd96;
            5'd4:    m = 7'd92;
            5'd5:    m = 7'd88;
            5'd6:    m = 7'd83;
            5'd7:    m = 7'd77;
            5'd8:    m = 7'd71;
            5'd9:    m = 7'd63;
            5'd10:   m = 7'd56;
            5'd11:   m = 7'd47;
            5'd12:   m = 7'd38;
            5'd13:   m = 7'd29;
            5'd14:   m = 7'd20;
            5'd15:   m = 7'd10;
            default: m = 7'd0;
        endcase
        return m;
    endfunction

    // Torque scaling in percent for each setting.
    function automatic logic [PCT_W-1:0] torque_pct(input logic [1:0] sel);
        logic [PCT_W-1:0] p;
        case (sel)
            2'b00:   p = 7'd100;
            2'b01:   p = 7'd75;
            2'b10:   p = 7'd50;
            default: p = 7'd20;
        endcase
        return p;
    endfunction

    // Position stride per step for each resolution.
    function automatic logic [POS_W-1:0] step_stride(input res_mode_e mode);
        logic [POS_W-1:0] s;
        case (mode)
            RES_FULL:      s = POS_W'(QTR_STEPS);
            RES_HALF:      s = POS_W'(QTR_STEPS / 2);
            RES_EIGHTH:    s = POS_W'(2);
            default:       s = POS_W'(1);
        endcase
        return s;
    endfunction

endpackage

// File: rtl/step_edge_sync.sv
// Synchronizes the asynchronous step clock and flags each rising edge.
// Assumes each level of the input lasts longer than STAGES+1 clock cycles.
module step_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES:0] chain;

    // Shift the input through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], async_in};
        end
    end

    // A rising edge shows up as a new 1 behind an old 0.
    always_comb begin
        rise = chain[STAGES-1] & ~chain[STAGES];
    end

endmodule

// File: rtl/step_position.sv
// Holds the electrical position and moves it by the stride of the resolution.
// Assumes the resolution changes only while the position is held at home.
module step_position
    import stepseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             home_n,
    input  logic             advance,
    input  logic             dir_ccw,
    input  res_mode_e        mode,
    output logic [POS_W-1:0] pos
);

    logic [POS_W-1:0] stride;

    // Stride for the current resolution.
    always_comb begin
        stride = step_stride(mode);
    end

    // Position register: cleared at reset and by home, moved on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (!home_n) begin
            pos <= '0;
        end else if (advance) begin
            pos <= dir_ccw ? (pos - stride) : (pos + stride);
        end
    end

endmodule

// File: rtl/coil_channel.sv
// Turns a position into one coil's signed, scaled and gated setpoint.
// OFFSET shifts the phase of this coil against the shared position.
module coil_channel
    import stepseq_pkg::*;
#(
    parameter int OFFSET = 0
) (
    input  logic [POS_W-1:0]        pos,
    input  res_mode_e               mode,
    input  logic [1:0]              torque_sel,
    input  logic                    enable,
    output logic signed [OUT_W-1:0] level
);

    localparam logic [POS_W-1:0] OFS = POS_W'(OFFSET);

    logic [POS_W-1:0]  phase;
    logic [1:0]        quad;
    logic [QTR_W-1:0]  rem;
    logic [QTR_W:0]    idx;
    logic              neg;
    logic [MAG_W-1:0]  mag;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic signed [OUT_W-1:0] mag_s;

    // Split the shifted phase into a quadrant and a remainder.
    always_comb begin
        phase = pos + OFS;
        quad  = phase[POS_W-1 -: 2];
        rem   = phase[QTR_W-1:0];
        neg   = quad[0] ^ quad[1];
        idx   = quad[0] ? ((QTR_W+1)'(QTR_STEPS) - {1'b0, rem}) : {1'b0, rem};
    end

    // Magnitude: fixed full current in full-step mode, table value otherwise.
    always_comb begin
        if (mode == RES_FULL) begin
            mag = MAG_W'(FULL_MAG);
        end else begin
            mag = quarter_mag(idx);
        end
    end

    // Scale by the torque percentage, rounding down.
    always_comb begin
        prod   = PROD_W'(mag) * PROD_W'(torque_pct(torque_sel));
        scaled = prod / PROD_W'(100);
        mag_s  = OUT_W'(scaled);
    end

    // Apply the sign after scaling, then gate with enable.
    always_comb begin
        if (!enable) begin
            level = '0;
        end else if (neg) begin
            level = -mag_s;
        end else begin
            level = mag_s;
        end
    end

endmodule

// File: rtl/stepper_phase_seq.sv
// Top level: step-edge detection, position counter and one channel per coil.
// Assumes home_n, mode_sel, torque_sel, enable and dir_in are synchronous to clk.
module stepper_phase_seq
    import stepseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_in,
    input  logic                    dir_in,
    input  logic [1:0]              mode_sel,
    input  logic [1:0]              torque_sel,
    input  logic                    home_n,
    input  logic                    enable,
    output logic signed [OUT_W-1:0] coil_a,
    output logic signed [OUT_W-1:0] coil_b,
    output logic                    at_home,
    output logic                    step_pulse
);

    logic             rise;
    logic             advance;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] eff_pos;
    res_mode_e        mode;
    logic signed [OUT_W-1:0] levels [NUM_COILS];

    // Decode the resolution input.
    always_comb begin
        mode = res_mode_e'(mode_sel);
    end

    step_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (step_in),
        .rise     (rise)
    );

    // A step counts only while the sequencer is not held at home.
    always_comb begin
        advance = rise & home_n;
    end

    step_position u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .home_n  (home_n),
        .advance (advance),
        .dir_ccw (dir_in),
        .mode    (mode),
        .pos     (pos)
    );

    // Step-event pulse, high in the cycle the new position appears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_pulse <= 1'b0;
        end else begin
            step_pulse <= advance;
        end
    end

    // Home hold shows position 0 at once; home flag follows.
    always_comb begin
        eff_pos = home_n ? pos : '0;
        at_home = ~home_n | (pos == '0);
    end

    for (genvar c = 0; c < NUM_COILS; c++) begin : g_coil
        coil_channel #(
            .OFFSET (c * QTR_STEPS)
        ) u_ch (
            .pos        (eff_pos),
            .mode       (mode),
            .torque_sel (torque_sel),
            .enable     (enable),
            .level      (levels[c])
        );
    end

    // Route the channels to the named coil outputs.
    always_comb begin
        coil_a = levels[0];
        coil_b = levels[1];
    end

endmodule

// File: rtl/stepper_phase_seq_checks.sv
// Port-level properties of the sequencer, bound to every instance of the top.
module stepper_phase_seq_checks (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_sel,
    input logic [1:0]        torque_sel,
    input logic              home_n,
    input logic              enable,
    input logic signed [7:0] coil_a,
    input logic signed [7:0] coil_b,
    input logic              at_home,
    input logic              step_pulse
);

    a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse |=> !step_pulse);

    a_r6_no_pulse_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !home_n |=> !step_pulse);

    a_r6_hold_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !home_n |-> at_home);

    a_r9_gated_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (coil_a == 8'sd0 && coil_b == 8'sd0));

    a_r4_home_value: assert property (@(posedge clk) disable iff (!rst_n)
        (!home_n && enable && torque_sel == 2'b00) |->
        (coil_a == 8'sd100 && coil_b == ((mode_sel == 2'b00) ? -8'sd100 : 8'sd0)));

    a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
        (coil_a <= 8'sd100 && coil_a >= -8'sd100 && coil_b <= 8'sd100 && coil_b >= -8'sd100));

    a_r11_still_without_step: assert property (@(posedge clk) disable iff (!rst_n)
        (home_n && $past(home_n) && !step_pulse && $stable(mode_sel)
         && $stable(torque_sel) && $stable(enable))
        |-> ($stable(coil_a) && $stable(coil_b)));

endmodule

bind stepper_phase_seq stepper_phase_seq_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .torque_sel (torque_sel),
    .home_n     (home_n),
    .enable     (enable),
    .coil_a     (coil_a),
    .coil_b     (coil_b),
    .at_home    (at_home),
    .step_pulse (step_pulse)
);

// File: tb/tb_stepper_phase_seq.sv
module tb_stepper_phase_seq;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_in = 1'b0;
    logic dir_in = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [1:0] torque_sel = 2'b00;
    logic home_n = 1'b1;
    logic enable = 1'b1;
    logic signed [7:0] coil_a;
    logic signed [7:0] coil_b;
    logic at_home;
    logic step_pulse;

    always #4 clk = ~clk;

    stepper_phase_seq dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_in    (step_in),
        .dir_in     (dir_in),
        .mode_sel   (mode_sel),
        .torque_sel (torque_sel),
        .home_n     (home_n),
        .enable     (enable),
        .coil_a     (coil_a),
        .coil_b     (coil_b),
        .at_home    (at_home),
        .step_pulse (step_pulse)
    );

    typedef struct {
        string tag;
        int    a;
        int    b;
        bit    home;
        bit    pulse;
    } exp_t;

    exp_t expq[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int m_pos = 0;
    int tbl[17] = '{100,100,98,96,92,88,83,77,71,63,56,47,38,29,20,10,0};

    // Model of one coil from the requirement text.
    function automatic int model_coil(int p, int mode, int tq, bit en);
        int q, r, mag, pct, s;
        q = (p / 16) % 4;
        r = p % 16;
        if (mode == 0) mag = 100;
        else mag = (q % 2 == 1) ? tbl[16 - r] : tbl[r];
        case (tq)
            0: pct = 100;
            1: pct = 75;
            2: pct = 50;
            default: pct = 20;
        endcase
        s = (mag * pct) / 100;
        if (!en) return 0;
        return (q == 1 || q == 2) ? -s : s;
    endfunction

    // Push the expected port values for the next falling-edge sample.
    task automatic expect_now(string tag, bit pulse);
        exp_t e;
        int p;
        p = home_n ? m_pos : 0;
        e.tag = tag;
        e.a = model_coil(p, mode_sel, torque_sel, enable);
        e.b = model_coil((p + 16) % 64, mode_sel, torque_sel, enable);
        e.home = !home_n || (m_pos == 0);
        e.pulse = pulse;
        expq.push_back(e);
    endtask

    // Monitor: pops each expectation and compares on the falling edge.
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            n_checks++;
            if (coil_a != e.a || coil_b != e.b || at_home != e.home || step_pulse != e.pulse) begin
                n_fail++;
                $display("FAIL %s: got a=%0d b=%0d home=%0d pulse=%0d, expected a=%0d b=%0d home=%0d pulse=%0d",
                         e.tag, coil_a, coil_b, at_home, step_pulse, e.a, e.b, e.home, e.pulse);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Driver: one step edge, checked when the pulse appears and after it falls.
    task automatic do_step(bit d, string tag);
        int stride;
        tick();
        dir_in = d;
        step_in = 1'b1;
        case (mode_sel)
            2'b00: stride = 16;
            2'b01: stride = 8;
            2'b10: stride = 1;
            default: stride = 2;
        endcase
        if (home_n) m_pos = d ? (m_pos - stride + 64) % 64 : (m_pos + stride) % 64;
        else m_pos = 0;
        repeat (2) @(posedge clk);
        tick();
        expect_now(tag, home_n);
        step_in = 1'b0;
        tick();
        expect_now({tag, " pulse end"}, 1'b0);
        repeat (3) tick();
    endtask

    // Switch resolution inside a home hold window.
    task automatic set_mode(logic [1:0] m, string tag);
        tick();
        home_n = 1'b0;
        tick();
        mode_sel = m;
        m_pos = 0;
        expect_now(tag, 1'b0);
        tick();
        home_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (3) tick();
        expect_now("R4 reset state full-step home", 1'b0);
        tick();
        rst_n = 1'b1;
        tick();

        // R3 R1: full-step sign sequence and wrap; R7 at the wrap.
        for (int i = 0; i < 4; i++) do_step(1'b0, "R3 R1 R7 full-step cw");

        set_mode(2'b10, "R4 R6 home in sixteenth mode");
        // R2: a whole electrical turn in sixteenth steps, R7 on return.
        for (int i = 0; i < 64; i++) do_step(1'b0, "R2 R7 sixteenth cw");
        // R5: counter-clockwise wraps below zero.
        for (int i = 0; i < 3; i++) do_step(1'b1, "R5 sixteenth ccw");

        // R6: a step edge during hold is ignored.
        tick();
        home_n = 1'b0;
        tick();
        expect_now("R6 hold shows home", 1'b0);
        do_step(1'b0, "R6 step ignored in hold");
        tick();
        home_n = 1'b1;
        tick();
        // R8: first step after release.
        do_step(1'b0, "R8 first step after release");

        set_mode(2'b11, "R4 home in eighth mode");
        for (int i = 0; i < 8; i++) do_step(1'b0, "R1 eighth cw");

        set_mode(2'b01, "R4 home in half mode");
        for (int i = 0; i < 4; i++) do_step(1'b0, "R1 half cw");
        for (int i = 0; i < 3; i++) do_step(1'b1, "R5 half ccw");

        // R10: torque settings at position 8 of half mode.
        for (int t = 1; t < 4; t++) begin
            tick();
            torque_sel = 2'(t);
            expect_now("R10 torque scaling", 1'b0);
        end
        tick();
        torque_sel = 2'b00;

        // R9: outputs gated, position still moves.
        tick();
        enable = 1'b0;
        expect_now("R9 disabled outputs zero", 1'b0);
        do_step(1'b0, "R9 step while disabled");
        do_step(1'b0, "R9 step while disabled");
        tick();
        enable = 1'b1;
        expect_now("R9 resume at advanced position", 1'b0);

        set_mode(2'b00, "R4 home in full-step mode");
        do_step(1'b1, "R5 R3 full-step ccw");

        repeat (4) tick();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule